// File: doc/BRIEF.md
# Flash sector protection controller

This block guards a program flash array against program and erase commands that touch locked addresses. It holds an 8-bit protection setting. That setting defines two address windows. The high window always ends at the top of the address space. The low window starts at a fixed base. A mode bit selects what the windows mean. With the mode bit at 1, each enabled window is a locked range and all other addresses are open. With the mode bit at 0, each enabled window is an open range and all other addresses are locked.

After reset the block fetches the protection setting from a nonvolatile configuration byte. If that read reports an uncorrectable error, the block falls back to locking the whole array. Software may then rewrite the setting, but only in a way that keeps every address that is already locked still locked. The command side judges each command in one cycle. An allowed command gets a grant pulse. A refused command gets a deny pulse and sets a sticky violation flag. Software clears that flag by writing 1 to it.

The controller has three states, each named in the source:
- `ST_FETCH` (reset state): waits for the configuration byte.
- `ST_READY`: judges commands.
- `ST_VIOL`: the violation flag is set.

It moves between them as follows:
- `ST_FETCH` → `ST_READY` when the fetch returns, whether or not the read reported an error.
- `ST_READY` → `ST_VIOL` on a refused command.
- `ST_VIOL` → `ST_READY` when software writes 1 to the flag.
- Every other case holds the current state.

Top module: `fprot_ctrl`

## Requirements
- R1: Reset state.
  - The block is in `ST_FETCH`.
  - `boot_rd_req` is 1 and `boot_rd_addr` is 0x3_FF0C.
  - `prot_q` is 0x7F.
  - `viol_flag`, `cmd_grant` and `cmd_deny` are 0.
- R2: Normal load. When `boot_rd_valid` is 1 without `boot_rd_dbe`, `prot_q` takes `boot_rd_data` in the next cycle, and `boot_rd_req` drops.
- R3: Error fallback. When `boot_rd_valid` comes with `boot_rd_dbe` at 1, `prot_q` becomes 0x7F. That value has the mode bit at 0 and every other bit at 1, so every address is locked.
- R4: Setting layout and mode 1.
  - Bit 7 is the mode bit.
  - Bit 6 is reserved.
  - Bit 5 disables the high window; bits 4:3 are its size.
  - Bit 2 disables the low window; bits 1:0 are its size.
  - With bit 7 at 1, an address is locked exactly when it falls inside an enabled window.
- R5: Mode 0. With bit 7 at 0, an address is locked exactly when it falls outside every enabled window.
- R6: Window sizes.
  - The high window spans 2 KB shifted left by its size code and ends at 0x3_FFFF.
  - The low window starts at 0x3_8000 and spans 1 KB shifted left by its size code.
- R7: A window's size field takes the written value only if that window's current disable bit is 1. Otherwise the size field keeps its value.
- R8: Grow-only writes.
  - A write to offset 0x8 is formed by merging the written byte with the current setting; bit 6 always keeps its value.
  - The merged value is taken only if it locks every address that the current setting locks.
  - Otherwise the write is ignored.
- R9: Command codes are 01 program, 10 sector erase, 11 block erase, and 00 no operation. A program or sector erase with a locked `cmd_addr` gives `cmd_deny` one cycle later and sets `viol_flag`. An open address gives `cmd_grant` instead.
- R10: A block erase is denied, with `viol_flag` set, if any address in the array is locked. Otherwise it is granted.
- R11: Writing 1 to bit 6 at offset 0x5 clears `viol_flag`.
- R12: While `viol_flag` is 1, every command is denied without a grant, and the flag stays 1 until it is cleared.
- R13: Commands that arrive in the same cycle as register writes:
  - A command that arrives with a setting write is judged against the setting held before the write.
  - A command that arrives with a flag clear while the flag is 1 is denied, and the flag still clears.
- R14: Before the configuration byte arrives, commands produce neither a grant nor a deny, and writes to the setting are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| boot_rd_req | output | 1 | Requests the configuration byte |
| boot_rd_addr | output | ADDR_W | Address of the configuration byte |
| boot_rd_valid | input | 1 | Configuration byte returned |
| boot_rd_data | input | 8 | Configuration byte |
| boot_rd_dbe | input | 1 | Uncorrectable error on the fetch |
| reg_wr_en | input | 1 | Register write strobe |
| reg_wr_off | input | 4 | Register offset (0x8 setting, 0x5 status) |
| reg_wr_data | input | 8 | Register write data |
| cmd_valid | input | 1 | Command present |
| cmd_op | input | 2 | Command code |
| cmd_addr | input | ADDR_W | Command target address |
| cmd_grant | output | 1 | Command allowed (one cycle after the command) |
| cmd_deny | output | 1 | Command refused (one cycle after the command) |
| prot_q | output | 8 | Current protection setting |
| viol_flag | output | 1 | Sticky violation flag |

## Verification
Two pairs of functions can meet in the same cycle:
- A setting write together with a command. The bench adds a high window while a program to 0x3_FFFF is in flight, so the expected grant shows that the pre-write setting was used.
- A flag clear together with a refused command. The bench raises both while the flag is set and expects a deny together with a cleared flag.

The bench also sends a refused command together with a clear while the flag is 0, and expects the flag to end up set.

// File: rtl/fprot_pkg.sv
package fprot_pkg;

    typedef struct packed {
        logic       open;
        logic       rsv;
        logic       hi_dis;
        logic [1:0] hi_sz;
        logic       lo_dis;
        logic [1:0] lo_sz;
    } prot_t;

    typedef enum logic [1:0] {
        OP_NONE   = 2'b00,
        OP_PROG   = 2'b01,
        OP_SECT   = 2'b10,
        OP_BLOCK  = 2'b11
    } op_e;

    typedef enum logic [1:0] {
        ST_FETCH = 2'b00,
        ST_READY = 2'b01,
        ST_VIOL  = 2'b10
    } state_e;

    localparam logic [7:0] FULL_LOCK = 8'h7F;
    localparam logic [3:0] OFF_STAT  = 4'h5;
    localparam logic [3:0] OFF_PROT  = 4'h8;
    localparam int         VIOL_BIT  = 6;

endpackage

// File: rtl/fprot_span.sv
module fprot_span #(
    parameter int                ADDR_W       = 18,
    parameter int                MIN_LOG2     = 10,
    parameter bit                TOP_ANCHORED = 1'b0,
    parameter logic [ADDR_W-1:0] BASE         = '0
) (
    input  logic [1:0]        size_code,
    input  logic [ADDR_W-1:0] addr,
    output logic              hit
);

    localparam logic [ADDR_W:0] MIN_SPAN = (ADDR_W+1)'(1) << MIN_LOG2;
    localparam logic [ADDR_W:0] SPACE    = (ADDR_W+1)'(1) << ADDR_W;

    logic [ADDR_W:0] span;
    logic [ADDR_W:0] addr_x;

    assign span   = MIN_SPAN << size_code;
    assign addr_x = {1'b0, addr};

    generate
        if (TOP_ANCHORED) begin : g_top
            // window ends at the last address of the space
            assign hit = addr_x >= (SPACE - span);
        end else begin : g_base
            logic [ADDR_W:0] base_x;
            logic [ADDR_W:0] end_x;
            assign base_x = {1'b0, BASE};
            assign end_x  = base_x + span;
            assign hit    = (addr_x >= base_x) && (addr_x < end_x);
        end
    endgenerate

endmodule

// File: rtl/fprot_decode.sv
module fprot_decode
    import fprot_pkg::*;
#(
    parameter int                ADDR_W      = 18,
    parameter int                HI_MIN_LOG2 = 11,
    parameter int                LO_MIN_LOG2 = 10,
    parameter logic [ADDR_W-1:0] LO_BASE     = 18'h38000
) (
    input  prot_t             cfg,
    input  logic [ADDR_W-1:0] addr,
    output logic              addr_locked,
    output logic              any_locked
);

    logic hi_hit;
    logic lo_hit;
    logic in_window;

    fprot_span #(
        .ADDR_W      (ADDR_W),
        .MIN_LOG2    (HI_MIN_LOG2),
        .TOP_ANCHORED(1'b1),
        .BASE        ('0)
    ) u_hi (
        .size_code(cfg.hi_sz),
        .addr     (addr),
        .hit      (hi_hit)
    );

    fprot_span #(
        .ADDR_W      (ADDR_W),
        .MIN_LOG2    (LO_MIN_LOG2),
        .TOP_ANCHORED(1'b0),
        .BASE        (LO_BASE)
    ) u_lo (
        .size_code(cfg.lo_sz),
        .addr     (addr),
        .hit      (lo_hit)
    );

    assign in_window = (hi_hit && !cfg.hi_dis) || (lo_hit && !cfg.lo_dis);

    always_comb begin
        if (cfg.open) begin
            addr_locked = in_window;
            any_locked  = !cfg.hi_dis || !cfg.lo_dis;
        end else begin
            addr_locked = !in_window;
            // open windows never cover the whole array
            any_locked  = 1'b1;
        end
    end

endmodule

// File: rtl/fprot_grow_check.sv
module fprot_grow_check
    import fprot_pkg::*;
(
    input  prot_t cur,
    input  prot_t cand,
    output logic  accept
);

    logic cur_hi_en, cur_lo_en, cand_hi_en, cand_lo_en;
    logic ok_hi, ok_lo;

    assign cur_hi_en  = !cur.hi_dis;
    assign cur_lo_en  = !cur.lo_dis;
    assign cand_hi_en = !cand.hi_dis;
    assign cand_lo_en = !cand.lo_dis;

    always_comb begin
        ok_hi = 1'b0;
        ok_lo = 1'b0;
        unique case ({cur.open, cand.open})
            2'b11: begin
                // locked windows must persist and not shrink
                ok_hi = !cur_hi_en || (cand_hi_en && cand.hi_sz >= cur.hi_sz);
                ok_lo = !cur_lo_en || (cand_lo_en && cand.lo_sz >= cur.lo_sz);
            end
            2'b00: begin
                // open windows may only shrink or vanish
                ok_hi = !cand_hi_en || (cur_hi_en && cand.hi_sz <= cur.hi_sz);
                ok_lo = !cand_lo_en || (cur_lo_en && cand.lo_sz <= cur.lo_sz);
            end
            2'b10: begin
                // new open windows must miss the old locked ones
                ok_hi = !(cand_hi_en && cur_hi_en);
                ok_lo = !(cand_lo_en && cur_lo_en);
            end
            default: begin
                // windows alone can never lock the full array
                ok_hi = 1'b0;
                ok_lo = 1'b0;
            end
        endcase
    end

    assign accept = ok_hi && ok_lo && (cand.rsv == cur.rsv);

endmodule

// File: rtl/fprot_ctrl.sv
module fprot_ctrl
    import fprot_pkg::*;
#(
    parameter int                ADDR_W      = 18,
    parameter int                HI_MIN_LOG2 = 11,
    parameter int                LO_MIN_LOG2 = 10,
    parameter logic [ADDR_W-1:0] LO_BASE     = 18'h38000,
    parameter logic [ADDR_W-1:0] CFG_ADDR    = 18'h3FF0C
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              boot_rd_req,
    output logic [ADDR_W-1:0] boot_rd_addr,
    input  logic              boot_rd_valid,
    input  logic [7:0]        boot_rd_data,
    input  logic              boot_rd_dbe,
    input  logic              reg_wr_en,
    input  logic [3:0]        reg_wr_off,
    input  logic [7:0]        reg_wr_data,
    input  logic              cmd_valid,
    input  logic [1:0]        cmd_op,
    input  logic [ADDR_W-1:0] cmd_addr,
    output logic              cmd_grant,
    output logic              cmd_deny,
    output logic [7:0]        prot_q,
    output logic              viol_flag
);

    state_e state_r, state_nxt;
    prot_t  prot_r;
    prot_t  cand;
    op_e    op;

    logic addr_locked;
    logic any_locked;
    logic grow_ok;
    logic wr_prot;
    logic wr_clear;
    logic cmd_live;
    logic cmd_bad;

    assign op       = op_e'(cmd_op);
    assign wr_prot  = reg_wr_en && (reg_wr_off == OFF_PROT);
    assign wr_clear = reg_wr_en && (reg_wr_off == OFF_STAT) && reg_wr_data[VIOL_BIT];
    assign cmd_live = cmd_valid && (op != OP_NONE);
    assign cmd_bad  = (op == OP_BLOCK) ? any_locked : addr_locked;

    // candidate setting: size fields follow their current disable bits
    always_comb begin
        cand.open   = reg_wr_data[7];
        cand.rsv    = prot_r.rsv;
        cand.hi_dis = reg_wr_data[5];
        cand.hi_sz  = prot_r.hi_dis ? reg_wr_data[4:3] : prot_r.hi_sz;
        cand.lo_dis = reg_wr_data[2];
        cand.lo_sz  = prot_r.lo_dis ? reg_wr_data[1:0] : prot_r.lo_sz;
    end

    fprot_decode #(
        .ADDR_W     (ADDR_W),
        .HI_MIN_LOG2(HI_MIN_LOG2),
        .LO_MIN_LOG2(LO_MIN_LOG2),
        .LO_BASE    (LO_BASE)
    ) u_decode (
        .cfg        (prot_r),
        .addr       (cmd_addr),
        .addr_locked(addr_locked),
        .any_locked (any_locked)
    );

    fprot_grow_check u_grow (
        .cur   (prot_r),
        .cand  (cand),
        .accept(grow_ok)
    );

    // next state
    always_comb begin
        state_nxt = state_r;
        unique case (state_r)
            ST_FETCH: if (boot_rd_valid) state_nxt = ST_READY;
            ST_READY: if (cmd_live && cmd_bad) state_nxt = ST_VIOL;
            ST_VIOL:  if (wr_clear) state_nxt = ST_READY;
            default:  state_nxt = ST_FETCH;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_r <= ST_FETCH;
        else        state_r <= state_nxt;
    end

    // protection setting
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prot_r <= prot_t'(FULL_LOCK);
        end else begin
            unique case (state_r)
                ST_FETCH: begin
                    if (boot_rd_valid)
                        prot_r <= boot_rd_dbe ? prot_t'(FULL_LOCK) : prot_t'(boot_rd_data);
                end
                ST_READY, ST_VIOL: begin
                    if (wr_prot && grow_ok) prot_r <= cand;
                end
                default: prot_r <= prot_r;
            endcase
        end
    end

    // command response pulses
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cmd_grant <= 1'b0;
            cmd_deny  <= 1'b0;
        end else begin
            cmd_grant <= 1'b0;
            cmd_deny  <= 1'b0;
            unique case (state_r)
                ST_READY: begin
                    cmd_grant <= cmd_live && !cmd_bad;
                    cmd_deny  <= cmd_live && cmd_bad;
                end
                ST_VIOL:  cmd_deny <= cmd_live;
                default: begin
                    cmd_grant <= 1'b0;
                    cmd_deny  <= 1'b0;
                end
            endcase
        end
    end

    assign boot_rd_req  = (state_r == ST_FETCH);
    assign boot_rd_addr = CFG_ADDR;
    assign prot_q       = prot_r;
    assign viol_flag    = (state_r == ST_VIOL);

endmodule

// File: rtl/fprot_ctrl_chk.sv
module fprot_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       boot_rd_req,
    input logic       boot_rd_valid,
    input logic [7:0] boot_rd_data,
    input logic       boot_rd_dbe,
    input logic       reg_wr_en,
    input logic [3:0] reg_wr_off,
    input logic [7:0] reg_wr_data,
    input logic       cmd_valid,
    input logic       cmd_grant,
    input logic       cmd_deny,
    input logic [7:0] prot_q,
    input logic       viol_flag
);

    logic clr;
    assign clr = reg_wr_en && (reg_wr_off == 4'h5) && reg_wr_data[6];

    // R2
    boot_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_rd_req && boot_rd_valid && !boot_rd_dbe) |=> (prot_q == $past(boot_rd_data)));

    // R3
    boot_fallback_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (boot_rd_req && boot_rd_valid && boot_rd_dbe) |=> (prot_q == 8'h7F));

    // R8
    rsv_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !boot_rd_req |=> $stable(prot_q[6]));

    // R9
    grant_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_grant |-> (!cmd_deny && !viol_flag));

    // R11
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_flag && clr) |=> !viol_flag);

    // R12
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_flag && !clr) |=> viol_flag);

    // R12
    flag_no_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (viol_flag && cmd_valid) |=> !cmd_grant);

    // R14
    fetch_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        boot_rd_req |=> (!cmd_grant && !cmd_deny));

endmodule

bind fprot_ctrl fprot_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .boot_rd_req  (boot_rd_req),
    .boot_rd_valid(boot_rd_valid),
    .boot_rd_data (boot_rd_data),
    .boot_rd_dbe  (boot_rd_dbe),
    .reg_wr_en    (reg_wr_en),
    .reg_wr_off   (reg_wr_off),
    .reg_wr_data  (reg_wr_data),
    .cmd_valid    (cmd_valid),
    .cmd_grant    (cmd_grant),
    .cmd_deny     (cmd_deny),
    .prot_q       (prot_q),
    .viol_flag    (viol_flag)
);

// File: tb/fprot_ctrl_test.sv
`timescale 1ns/1ps
module fprot_ctrl_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        boot_rd_req;
    logic [17:0] boot_rd_addr;
    logic        boot_rd_valid = 1'b0;
    logic [7:0]  boot_rd_data = 8'h00;
    logic        boot_rd_dbe = 1'b0;
    logic        reg_wr_en = 1'b0;
    logic [3:0]  reg_wr_off = 4'h0;
    logic [7:0]  reg_wr_data = 8'h00;
    logic        cmd_valid = 1'b0;
    logic [1:0]  cmd_op = 2'b00;
    logic [17:0] cmd_addr = '0;
    logic        cmd_grant, cmd_deny, viol_flag;
    logic [7:0]  prot_q;

    always #4 clk = ~clk;

    fprot_ctrl uut (
        .clk(clk), .rst_n(rst_n),
        .boot_rd_req(boot_rd_req), .boot_rd_addr(boot_rd_addr),
        .boot_rd_valid(boot_rd_valid), .boot_rd_data(boot_rd_data), .boot_rd_dbe(boot_rd_dbe),
        .reg_wr_en(reg_wr_en), .reg_wr_off(reg_wr_off), .reg_wr_data(reg_wr_data),
        .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_addr(cmd_addr),
        .cmd_grant(cmd_grant), .cmd_deny(cmd_deny), .prot_q(prot_q), .viol_flag(viol_flag)
    );

    typedef struct {
        bit         grant;
        bit         deny;
        bit         flag;
        logic [7:0] prot;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   checks = 0;
    int   errors = 0;
    bit   done = 1'b0;

    logic [7:0] m_prot;
    bit         m_flag;
    bit         m_ready;

    // model of R4, R5, R6
    function automatic bit m_locked(logic [7:0] p, int a);
        int  hspan = 2048 << p[4:3];
        int  lspan = 1024 << p[1:0];
        bit  hh = !p[5] && (a >= 262144 - hspan);
        bit  lh = !p[2] && (a >= 32'h38000) && (a < 32'h38000 + lspan);
        return p[7] ? (hh || lh) : !(hh || lh);
    endfunction

    function automatic bit m_any(logic [7:0] p);
        for (int i = 0; i < 256; i++) if (m_locked(p, i * 1024)) return 1'b1;
        return 1'b0;
    endfunction

    function automatic bit m_superset(logic [7:0] old_p, logic [7:0] new_p);
        for (int i = 0; i < 256; i++)
            if (m_locked(old_p, i * 1024) && !m_locked(new_p, i * 1024)) return 1'b0;
        return 1'b1;
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        boot_rd_valid = 1'b0;
        reg_wr_en = 1'b0;
        cmd_valid = 1'b0;
        m_prot = 8'h7F; m_flag = 1'b0; m_ready = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        checks++;
        if (!(boot_rd_req === 1'b1 && boot_rd_addr === 18'h3FF0C && prot_q === 8'h7F &&
              viol_flag === 1'b0 && cmd_grant === 1'b0 && cmd_deny === 1'b0)) begin
            errors++;
            $display("FAIL R1 reset: req=%b addr=%h prot=%h flag=%b g=%b d=%b expected 1 3ff0c 7f 0 0 0",
                     boot_rd_req, boot_rd_addr, prot_q, viol_flag, cmd_grant, cmd_deny);
        end
    endtask

    task automatic boot(logic [7:0] d, bit dbe, string tag);
        exp_t e;
        @(negedge clk);
        reg_wr_en = 1'b0; cmd_valid = 1'b0;
        boot_rd_valid = 1'b1; boot_rd_data = d; boot_rd_dbe = dbe;
        m_prot = dbe ? 8'h7F : d;
        m_ready = 1'b1;
        e.grant = 1'b0; e.deny = 1'b0; e.flag = 1'b0; e.prot = m_prot; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic apply(bit we, logic [3:0] off, logic [7:0] d,
                         bit cv, logic [1:0] op, logic [17:0] a, string tag);
        exp_t e;
        bit clr, wp, live, bad;
        logic [7:0] cand, np;
        bit nf;
        @(negedge clk);
        boot_rd_valid = 1'b0;
        reg_wr_en = we; reg_wr_off = off; reg_wr_data = d;
        cmd_valid = cv; cmd_op = op; cmd_addr = a;
        clr  = we && off == 4'h5 && d[6];
        wp   = we && off == 4'h8;
        live = cv && op != 2'b00;
        e.grant = 1'b0; e.deny = 1'b0;
        nf = m_flag; np = m_prot;
        if (m_ready) begin
            if (m_flag) begin
                e.deny = live;
                if (clr) nf = 1'b0;
            end else if (live) begin
                bad = (op == 2'b11) ? m_any(m_prot) : m_locked(m_prot, int'(a));
                e.grant = !bad; e.deny = bad;
                if (bad) nf = 1'b1;
            end
            if (wp) begin
                cand = {d[7], m_prot[6], d[5],
                        m_prot[5] ? d[4:3] : m_prot[4:3],
                        d[2],
                        m_prot[2] ? d[1:0] : m_prot[1:0]};
                if (m_superset(m_prot, cand)) np = cand;
            end
        end
        m_flag = nf; m_prot = np;
        e.flag = nf; e.prot = np; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic cmd(logic [1:0] op, logic [17:0] a, string tag);
        apply(1'b0, 4'h0, 8'h00, 1'b1, op, a, tag);
    endtask

    task automatic wr(logic [3:0] off, logic [7:0] d, string tag);
        apply(1'b1, off, d, 1'b0, 2'b00, 18'h0, tag);
    endtask

    task automatic idle();
        apply(1'b0, 4'h0, 8'h00, 1'b0, 2'b00, 18'h0, "idle");
        @(negedge clk);
        cmd_valid = 1'b0; reg_wr_en = 1'b0;
    endtask

    // monitor: compare one expected item per cycle after each edge
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                checks++;
                if (cmd_grant !== e.grant || cmd_deny !== e.deny ||
                    viol_flag !== e.flag || prot_q !== e.prot) begin
                    errors++;
                    $display("FAIL %s: g=%b d=%b flag=%b prot=%h expected g=%b d=%b flag=%b prot=%h",
                             e.tag, cmd_grant, cmd_deny, viol_flag, prot_q,
                             e.grant, e.deny, e.flag, e.prot);
                end
            end
        end
    end

    initial begin
        #(8 * 100000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        // R1, R14, R3
        do_reset();
        cmd(2'b01, 18'h00000, "R14 prog before load");
        wr(4'h8, 8'hFF, "R14 write before load");
        boot(8'hFF, 1'b1, "R3 dbe fallback");
        cmd(2'b01, 18'h00000, "R5 locked by fallback");
        cmd(2'b01, 18'h10000, "R12 denied while flagged");
        wr(4'h5, 8'h40, "R11 clear flag");
        idle();

        // R2, R4, R6, R7, R8, R9, R10
        do_reset();
        boot(8'hFF, 1'b0, "R2 normal load");
        cmd(2'b01, 18'h3FFFF, "R4 no windows open");
        cmd(2'b11, 18'h00000, "R10 block erase granted");
        wr(4'h8, 8'h8F, "R8 add high window");
        cmd(2'b01, 18'h3F000, "R6 high window low edge");
        cmd(2'b10, 18'h3FFFF, "R12 while flagged");
        wr(4'h5, 8'h40, "R11 clear");
        cmd(2'b01, 18'h3EFFF, "R6 below high window");
        cmd(2'b11, 18'h00000, "R10 block erase refused");
        wr(4'h5, 8'h40, "R11 clear");
        wr(4'h8, 8'h9F, "R7 size locked while enabled");
        cmd(2'b01, 18'h3EFFF, "R7 window not grown");
        wr(4'h8, 8'hAF, "R8 shrink rejected");
        wr(4'h8, 8'h88, "R8 add low window");
        cmd(2'b01, 18'h383FF, "R6 low window top");
        wr(4'h5, 8'h40, "R11 clear");
        cmd(2'b01, 18'h38400, "R6 above low window");
        cmd(2'b01, 18'h37FFF, "R6 below low base");
        cmd(2'b00, 18'h3FFFF, "R9 no-op ignored");
        wr(4'h8, 8'h27, "R8 switch to mode 0 full lock");
        cmd(2'b01, 18'h00000, "R5 mode 0 locked");
        wr(4'h5, 8'h40, "R11 clear");
        wr(4'h8, 8'h0C, "R8 open window rejected");
        wr(4'h8, 8'hFF, "R8 mode 1 rejected");
        idle();

        // R13
        do_reset();
        boot(8'hFF, 1'b0, "R2 load");
        apply(1'b1, 4'h8, 8'hDF, 1'b1, 2'b01, 18'h3FFFF, "R13 write with command");
        cmd(2'b01, 18'h3FFFF, "R9 locked program");
        apply(1'b1, 4'h5, 8'h40, 1'b1, 2'b01, 18'h3FFFF, "R13 clear with command");
        apply(1'b1, 4'h5, 8'h40, 1'b1, 2'b10, 18'h3C000, "R13 clear while flag low");
        wr(4'h5, 8'h40, "R11 clear");
        cmd(2'b01, 18'h00000, "R9 open program");
        idle();

        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule